// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter

This unit turns a signed integer into an IEEE-754 single-precision value. It rounds the value according to a rounding-mode input that can change on every operation, and it places the value in the lowest 32-bit lane of a 128-bit vector result. The source is 64 bits wide. The full 64 bits are converted only when the operand-size request and the 64-bit-mode flag are both set. Otherwise the low 32 bits are converted as a signed word. An inexact flag reports every conversion that lost precision. No other floating-point condition can arise from this operation.

Lanes 1 to 3 of the result always come from the merge-source input. In the legacy form, the merge source is the old destination contents, and everything above bit 127 of the wider register stays as it was. In the three-operand form, the merge source is the second vector operand, and the unit asks for everything above bit 127 to be cleared. The unit captures its inputs on a cycle where `in_valid` is high and presents the result one clock later.

Top module: `int2sp_cvt`

## Requirements
- R1: An operation accepted with `in_valid` high appears on the outputs, with `out_valid` high, exactly one clock later. `out_valid` is low out of reset and on every cycle after a cycle with `in_valid` low.
- R2: When `op_wide` and `mode64` are both 1, the whole 64-bit `src_int` is converted as a signed two's-complement value.
- R3: When `op_wide` is 1 but `mode64` is 0, the wide request is ignored. Only `src_int[31:0]` is converted, as a signed 32-bit value, and bits 63:32 have no effect.
- R4: `result[31:0]` is laid out as sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0. A negative input sets bit 31 and encodes its magnitude. The most negative 64-bit value gives 0xDF000000 and the most negative 32-bit value gives 0xCF000000, both exact.
- R5: A zero source gives 0x00000000 with `inexact` low.
- R6: `rnd_mode` selects the rounding of inexact values: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R7: When rounding carries out of the 24-bit significand, the exponent goes up by one and the fraction becomes zero. For example, 0x7FFFFFFF rounded to nearest gives 0x4F000000.
- R8: `inexact` is 1 exactly when the value delivered differs from the integer. Every integer whose magnitude is at most 2^24 is exact.
- R9: `result[127:32]` equals `merge_src[127:32]` as captured with the operation, in both forms.
- R10: `zero_upper` is 1 for an operation in the three-operand form (`form_3op` = 1) and 0 for the legacy form.
- R11: While `in_valid` is low, `result`, `zero_upper` and `inexact` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Capture an operation this cycle |
| src_int | input | 64 | Signed integer source |
| op_wide | input | 1 | Request a 64-bit operand |
| mode64 | input | 1 | 64-bit mode is active |
| rnd_mode | input | 2 | Rounding mode (see R6) |
| form_3op | input | 1 | 1 = three-operand form, 0 = legacy form |
| merge_src | input | 128 | Vector supplying bits 127:32 of the result |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 128 | Converted value in bits 31:0 with merged upper lanes |
| zero_upper | output | 1 | Clear bits above 127 of the wider destination |
| inexact | output | 1 | Precision flag for this conversion |

## Verification
Hand-picked values probe the points where a converter tends to go wrong: zero, plus and minus one, the most negative 32-bit and 64-bit values, 2^24 + 1 under each rounding mode (an exact tie), 0x7FFFFFFF (a carry into the exponent), and a wide request made outside 64-bit mode with junk in the upper half. Together they separate a sign-magnitude error from a rounding error or an operand-selection error. Random 64-bit and 32-bit sources under all four rounding modes then exercise the guard and sticky logic against a reference model in the bench. That model finds the dropped remainder by subtraction and compares it with the half-way point, rather than using guard and sticky bits. Idle cycles with the other inputs changing show that the outputs hold, and alternating forms check the merge rule and the zeroing indication.

// File: rtl/int2sp_pkg.sv
package int2sp_pkg;
  parameter int SRC_W  = 64;
  parameter int NARW_W = 32;
  parameter int LANE_W = 32;
  parameter int VEC_W  = 128;
  parameter int EXP_W  = 8;
  parameter int MAN_W  = 23;
  parameter int BIAS   = 127;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/cvt_operand.sv
// Chooses the active operand width and splits it into sign and magnitude.
module cvt_operand #(
  parameter int SRC_W  = 64,
  parameter int NARW_W = 32
) (
  input  logic [SRC_W-1:0] src,
  input  logic             op_wide,
  input  logic             mode64,
  output logic             sign,
  output logic [SRC_W-1:0] mag
);
  localparam int EXT_W = SRC_W - NARW_W;

  logic             use_wide;
  logic [SRC_W-1:0] val;

  always_comb begin
    // A wide request only counts inside 64-bit mode.
    use_wide = op_wide & mode64;
    if (use_wide) val = src;
    else          val = {{EXT_W{src[NARW_W-1]}}, src[NARW_W-1:0]};
    sign = val[SRC_W-1];
    // The unsigned negation of the most negative value is its own magnitude.
    mag  = sign ? (~val + {{(SRC_W-1){1'b0}}, 1'b1}) : val;
  end
endmodule

// File: rtl/cvt_lzc.sv
// Leading-zero counter; the scan length follows the parameter width.
module cvt_lzc #(
  parameter int W  = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
    all_zero = ~|vec;
  end
endmodule

// File: rtl/cvt_round.sv
// Normalizes the magnitude, rounds by mode and packs the single-precision word.
module cvt_round
  import int2sp_pkg::*;
#(
  parameter int SW  = 64,
  parameter int EW  = 8,
  parameter int MW  = 23,
  parameter int BS  = 127,
  localparam int CW = $clog2(SW),
  localparam int FW = 1 + EW + MW
) (
  input  logic          sign,
  input  logic [SW-1:0] mag,
  input  logic [CW-1:0] lz,
  input  logic          is_zero,
  input  logic [1:0]    rnd,
  output logic [FW-1:0] fp,
  output logic          inexact
);
  localparam int SIG_W = MW + 1;
  localparam int DROP  = SW - SIG_W;
  localparam int TOP_E = BS + SW - 1;

  logic [SW-1:0]    norm;
  logic [SIG_W-1:0] sig;
  logic             guard;
  logic             sticky;
  logic             lost;
  logic             bump;
  logic [SIG_W:0]   sum;
  logic             carry;
  logic [EW-1:0]    exp_pre;
  logic [EW-1:0]    exp_fin;
  logic [MW-1:0]    frac;
  rnd_mode_e        mode;

  always_comb begin
    norm    = mag << lz;
    sig     = norm[SW-1 -: SIG_W];
    guard   = norm[DROP-1];
    sticky  = |norm[DROP-2:0];
    lost    = guard | sticky;
    exp_pre = EW'(TOP_E) - EW'(lz);
    mode    = rnd_mode_e'(rnd);
    unique case (mode)
      RND_NEAR: bump = guard & (sticky | sig[0]);
      RND_DOWN: bump = sign & lost;
      RND_UP:   bump = ~sign & lost;
      default:  bump = 1'b0;
    endcase
    sum     = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
    carry   = sum[SIG_W];
    exp_fin = exp_pre + {{(EW-1){1'b0}}, carry};
    frac    = carry ? '0 : sum[MW-1:0];
    if (is_zero) begin
      fp      = '0;
      inexact = 1'b0;
    end else begin
      fp      = {sign, exp_fin, frac};
      inexact = lost;
    end
  end
endmodule

// File: rtl/int2sp_cvt.sv
module int2sp_cvt
  import int2sp_pkg::*;
#(
  parameter int SW  = SRC_W,
  parameter int NW  = NARW_W,
  parameter int LW  = LANE_W,
  parameter int VW  = VEC_W,
  parameter int EW  = EXP_W,
  parameter int MW  = MAN_W,
  parameter int BS  = BIAS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] src_int,
  input  logic          op_wide,
  input  logic          mode64,
  input  logic [1:0]    rnd_mode,
  input  logic          form_3op,
  input  logic [VW-1:0] merge_src,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          zero_upper,
  output logic          inexact
);
  localparam int LANES = VW / LW;
  localparam int CW    = $clog2(SW);
  localparam int FW    = 1 + EW + MW;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_n, rst_s2_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  logic          sign;
  logic [SW-1:0] mag;
  logic [CW-1:0] lz;
  logic          is_zero;
  logic [FW-1:0] fp;
  logic          fp_inexact;

  cvt_operand #(.SRC_W(SW), .NARW_W(NW)) u_operand (
    .src(src_int), .op_wide(op_wide), .mode64(mode64),
    .sign(sign), .mag(mag)
  );

  cvt_lzc #(.W(SW)) u_lzc (
    .vec(mag), .cnt(lz), .all_zero(is_zero)
  );

  cvt_round #(.SW(SW), .EW(EW), .MW(MW), .BS(BS)) u_round (
    .sign(sign), .mag(mag), .lz(lz), .is_zero(is_zero), .rnd(rnd_mode),
    .fp(fp), .inexact(fp_inexact)
  );

  // Lane assembly: lane 0 takes the converted value, the others merge.
  logic [VW-1:0] vec_nxt;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign vec_nxt[LW-1:0] = LW'(fp);
    end else begin : g_merge
      assign vec_nxt[g*LW +: LW] = merge_src[g*LW +: LW];
    end
  end

  // Next-state logic with an explicit capture enable.
  logic          valid_d, zup_d, inx_d;
  logic [VW-1:0] res_d;
  always_comb begin
    valid_d = in_valid;
    res_d   = result;
    zup_d   = zero_upper;
    inx_d   = inexact;
    if (in_valid) begin
      res_d = vec_nxt;
      zup_d = form_3op;
      inx_d = fp_inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_s2_n) begin
    if (!rst_s2_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      zero_upper <= 1'b0;
      inexact    <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      result     <= res_d;
      zero_upper <= zup_d;
      inexact    <= inx_d;
    end
  end
endmodule

// File: rtl/int2sp_cvt_chk.sv
module int2sp_cvt_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [63:0]  src_int,
  input logic         op_wide,
  input logic         mode64,
  input logic         form_3op,
  input logic [127:0] merge_src,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         zero_upper,
  input logic         inexact
);
  logic src_zero;
  assign src_zero = (op_wide && mode64) ? (src_int == 64'd0) : (src_int[31:0] == 32'd0);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_zero) |=> (result[31:0] == 32'd0 && !inexact));
  a_r8_inexact_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && inexact) |-> (result[30:0] != 31'd0));
  a_r9_merge: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (result[127:32] == $past(merge_src[127:32])));
  a_r10_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (zero_upper == $past(form_3op)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> ($stable(result) && $stable(inexact) && $stable(zero_upper)));
endmodule

bind int2sp_cvt int2sp_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
  .op_wide(op_wide), .mode64(mode64), .form_3op(form_3op), .merge_src(merge_src),
  .out_valid(out_valid), .result(result), .zero_upper(zero_upper), .inexact(inexact)
);

// File: tb/int2sp_cvt_test.sv
`timescale 1ns/1ps
module int2sp_cvt_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [63:0]  src_int;
  logic         op_wide;
  logic         mode64;
  logic [1:0]   rnd_mode;
  logic         form_3op;
  logic [127:0] merge_src;
  logic         out_valid;
  logic [127:0] result;
  logic         zero_upper;
  logic         inexact;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  int2sp_cvt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
    .op_wide(op_wide), .mode64(mode64), .rnd_mode(rnd_mode), .form_3op(form_3op),
    .merge_src(merge_src), .out_valid(out_valid), .result(result),
    .zero_upper(zero_upper), .inexact(inexact)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: remainder is compared with the half-way point.
  function automatic logic [32:0] model(input logic [63:0] s, input logic w, input logic m, input logic [1:0] rm);
    logic [63:0] v, mg, q, rem, half;
    logic neg, inx, up;
    int e, sh;
    v = (w && m) ? s : {{32{s[31]}}, s[31:0]};
    neg = v[63];
    mg = neg ? (64'd0 - v) : v;
    if (mg == 64'd0) return 33'd0;
    e = 63;
    while (!mg[e]) e--;
    inx = 1'b0; up = 1'b0;
    if (e <= 23) q = mg << (23 - e);
    else begin
      sh = e - 23;
      q = mg >> sh;
      rem = mg - (q << sh);
      half = 64'd1 << (sh - 1);
      inx = (rem != 64'd0);
      case (rm)
        2'b00: up = (rem > half) || (rem == half && q[0]);
        2'b01: up = neg && inx;
        2'b10: up = !neg && inx;
        default: up = 1'b0;
      endcase
    end
    q = q + {63'd0, up};
    if (q[24]) begin q = q >> 1; e++; end
    return {inx, neg, 8'(e + 127), q[22:0]};
  endfunction

  // Drive at a falling edge; results are compared at the next falling edge.
  task automatic apply(input logic [63:0] s, input logic w, input logic m, input logic [1:0] rm,
                       input logic f3, input logic [127:0] mg, input logic [31:0] exp_fp,
                       input logic exp_inx, input string req);
    in_valid = 1'b1; src_int = s; op_wide = w; mode64 = m; rnd_mode = rm;
    form_3op = f3; merge_src = mg;
    @(negedge clk);
    check(out_valid === 1'b1, "R1 out_valid", {127'd0, out_valid}, 128'd1);
    check(result[31:0] === exp_fp, req, {96'd0, result[31:0]}, {96'd0, exp_fp});
    check(inexact === exp_inx, "R8 inexact", {127'd0, inexact}, {127'd0, exp_inx});
    check(result[127:32] === mg[127:32], "R9 merge", {32'd0, result[127:32]}, {32'd0, mg[127:32]});
    check(zero_upper === f3, "R10 zero_upper", {127'd0, zero_upper}, {127'd0, f3});
  endtask

  task automatic apply_model(input logic [63:0] s, input logic w, input logic m, input logic [1:0] rm,
                             input logic f3, input logic [127:0] mg, input string req);
    logic [32:0] r;
    r = model(s, w, m, rm);
    apply(s, w, m, rm, f3, mg, r[31:0], r[32], req);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] held;
    logic         held_inx, held_zu;
    rst_n = 1'b0; in_valid = 1'b0; src_int = '0; op_wide = 1'b0; mode64 = 1'b0;
    rnd_mode = 2'b00; form_3op = 1'b0; merge_src = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R1 idle after reset", {127'd0, out_valid}, 128'd0);

    // Directed values with hand-worked encodings.
    apply(64'd0, 1, 1, 2'b00, 0, rnd128(), 32'h0000_0000, 0, "R5 zero");
    apply(64'd1, 0, 0, 2'b00, 1, rnd128(), 32'h3F80_0000, 0, "R4 one");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'b00, 0, rnd128(), 32'hBF80_0000, 0, "R4 minus one");
    apply(64'h8000_0000_0000_0000, 1, 1, 2'b00, 1, rnd128(), 32'hDF00_0000, 0, "R2 R4 min64");
    apply(64'h0000_0000_8000_0000, 0, 1, 2'b00, 0, rnd128(), 32'hCF00_0000, 0, "R4 min32");
    apply(64'hFFFF_FFFF_0000_0001, 1, 0, 2'b00, 0, rnd128(), 32'h3F80_0000, 0, "R3 wide ignored");
    apply(64'h1234_5678_0000_0000, 1, 0, 2'b10, 1, rnd128(), 32'h0000_0000, 0, "R3 R5 upper ignored");
    apply(64'h0000_0000_7FFF_FFFF, 0, 0, 2'b00, 0, rnd128(), 32'h4F00_0000, 1, "R7 carry");
    apply(64'd16777216, 0, 0, 2'b10, 0, rnd128(), 32'h4B80_0000, 0, "R8 exact 2^24");
    apply(64'd16777217, 0, 0, 2'b00, 0, rnd128(), 32'h4B80_0000, 1, "R6 tie even");
    apply(64'd16777217, 0, 0, 2'b10, 0, rnd128(), 32'h4B80_0001, 1, "R6 plus inf");
    apply(64'd16777217, 0, 0, 2'b11, 0, rnd128(), 32'h4B80_0000, 1, "R6 to zero");
    apply(64'd16777217, 0, 0, 2'b01, 0, rnd128(), 32'h4B80_0000, 1, "R6 minus inf pos");
    apply(-64'sd16777217, 1, 1, 2'b01, 1, rnd128(), 32'hCB80_0001, 1, "R6 minus inf neg");
    apply(64'd16777219, 0, 0, 2'b00, 0, rnd128(), 32'h4B80_0002, 1, "R6 tie up to even");
    apply(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 2'b11, 0, rnd128(), 32'h5EFF_FFFF, 1, "R2 R6 max64 to zero");

    // Hold while idle.
    held = result; held_inx = inexact; held_zu = zero_upper;
    in_valid = 1'b0; src_int = 64'h5555_0000_1234_0001; form_3op = ~form_3op;
    merge_src = rnd128(); rnd_mode = 2'b10;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 idle", {127'd0, out_valid}, 128'd0);
    check(result === held, "R11 hold result", result, held);
    check(inexact === held_inx && zero_upper === held_zu, "R11 hold flags",
          {126'd0, inexact, zero_upper}, {126'd0, held_inx, held_zu});

    // Random sources under every rounding mode and both widths.
    for (int i = 0; i < 600; i++) begin
      logic [63:0] s;
      logic [1:0] rm;
      s = {$urandom, $urandom};
      if (i % 5 == 1) s = s >> ($urandom % 64);
      rm = 2'(i);
      apply_model(s, 1, 1, rm, i[2], rnd128(), "R2 R6 random wide");
      apply_model(s, 0, i[3], rm, !i[2], rnd128(), "R3 R6 random narrow");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule